// File: doc/BRIEF.md
# SDRAM Command Decoder with Bank State Tracking

This block is the front end of a synchronous DRAM device model. On every rising clock edge it samples the chip select, row strobe, column strobe, write enable, clock enable, bank select and address pins. It turns them into a one-hot command strobe and latches the address, bank and auto-precharge information that the command carries. It also keeps an idle/active flag for each of the four banks.

Each command is checked against the current bank state. An activate to an open bank, a read or write to a closed bank, and a mode-set or refresh while any bank is open all raise an illegal flag, and the bank state is left as it was. The clock enable pin selects self-refresh, clock suspend (when a burst is running, as reported by the data path) or power-down. While the device is in any of these modes, pin activity is ignored until clock enable is sampled high again.

Top module: `sdram_cmd_decode`

## Requirements
- R1: When chip select is sampled high, the command is deselect (strobe bit 0). The bank state is unchanged, whatever the other pins carry.
- R2: The pins {cs_n,ras_n,cas_n,we_n} decode onto strobe bits as follows: 0111 no-op (bit 1), 0110 burst stop (bit 10), 0101 read (bit 6), 0100 write (bit 5), 0011 activate (bit 2), 0010 precharge (bit 3, or bit 4 for all banks), 0001 auto refresh (bit 8, or bit 9 self-refresh when cke is low), 0000 mode set (bit 7).
- R3: Activate is legal only when the bank selected by ba (0 to 3 address banks 0 to 3, bank_active bit i) is idle, and it makes that bank active.
- R4: Read and write are legal only when the target bank is active. They leave the bank active.
- R5: Precharge with addr[10] low makes the selected bank idle. With addr[10] high it makes every bank idle.
- R6: Mode set, auto refresh and self-refresh entry are legal only when every bank is idle.
- R7: An illegal command sets `illegal` for that cycle and leaves bank_active unchanged.
- R8: When cke is sampled low after being high, the block enters one mode. A legal self-refresh entry selects self-refresh. Otherwise `burst_busy` high selects clock suspend, and `burst_busy` low selects power-down.
- R9: At an edge where the previous sample of cke was low, no command is decoded: the strobe is all zero and the state is frozen. The mode flag clears at the edge where cke is sampled high.
- R10: All outputs are registered and reflect the command sampled at the previous rising edge. Reset clears the strobe, illegal flag, modes and all bank flags.
- R11: Activate and mode set latch the 12-bit address. Read and write latch the 9-bit column, zero-extended, together with auto-precharge = addr[10]. Activate, precharge, read and write latch the bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| cke | input | 1 | Clock enable |
| ba | input | 2 | Bank select |
| addr | input | 12 | Row, column or opcode address |
| burst_busy | input | 1 | Data path reports a burst in progress |
| cmd | output | 11 | One-hot decoded command strobe |
| illegal | output | 1 | Last command was illegal for the bank state |
| cmd_addr | output | 12 | Latched row, column or opcode |
| cmd_bank | output | 2 | Latched target bank |
| auto_pre | output | 1 | Last read/write requested auto-precharge |
| bank_active | output | 4 | Per-bank active flags |
| pwr_down | output | 1 | Power-down mode |
| self_ref | output | 1 | Self-refresh mode |
| clk_susp | output | 1 | Clock suspend mode |

## Verification
The bench sends a second activate to an open bank. A design that skipped the legality check would hide the fault silently. It also reads a closed bank, and refreshes or sets the mode while a bank is open. It checks precharge with address bit 10 both low and high, because a decoder that ignored bit 10 would close one bank where it should close all of them. It then drops clock enable with and without a burst in progress, and with a refresh pattern. A design that mixed up the three modes would raise the wrong status flag. A design that kept decoding while clock enable was low would open banks during power-down. Finally, a decoder that failed to mask on chip select would open a bank during a deselect that carries an activate pattern.

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode #(
  parameter int ROW_W  = 12,
  parameter int COL_W  = 9,
  parameter int AP_BIT = 10,
  parameter int NBANK  = 4,
  localparam int BA_W  = $clog2(NBANK),
  localparam int NCMD  = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             ras_n,
  input  logic             cas_n,
  input  logic             we_n,
  input  logic             cke,
  input  logic [BA_W-1:0]  ba,
  input  logic [ROW_W-1:0] addr,
  input  logic             burst_busy,
  output logic [NCMD-1:0]  cmd,
  output logic             illegal,
  output logic [ROW_W-1:0] cmd_addr,
  output logic [BA_W-1:0]  cmd_bank,
  output logic             auto_pre,
  output logic [NBANK-1:0] bank_active,
  output logic             pwr_down,
  output logic             self_ref,
  output logic             clk_susp
);
  localparam int C_DES = 0, C_NOP = 1, C_ACT = 2, C_PRE = 3, C_PALL = 4, C_WR = 5,
                 C_RD = 6, C_MRS = 7, C_REF = 8, C_SREF = 9, C_BST = 10;

  logic            cke_q;
  logic [NCMD-1:0] dec;
  logic [NBANK-1:0] bank_n;

  wire [3:0] pins     = {cs_n, ras_n, cas_n, we_n};
  wire       all_idle = ~|bank_active;
  wire       tgt_act  = bank_active[ba];
  wire       rw       = dec[C_RD] | dec[C_WR];
  wire       bad      = (dec[C_ACT] & tgt_act) | (rw & ~tgt_act) |
                        ((dec[C_MRS] | dec[C_REF] | dec[C_SREF]) & ~all_idle);
  wire       enter    = cke_q & ~cke;
  wire       sref_ok  = dec[C_SREF] & ~bad;

  always_comb begin
    dec = '0;
    if (cke_q) begin
      casez (pins)
        4'b1???: dec[C_DES] = 1'b1;
        4'b0111: dec[C_NOP] = 1'b1;
        4'b0110: dec[C_BST] = 1'b1;
        4'b0101: dec[C_RD]  = 1'b1;
        4'b0100: dec[C_WR]  = 1'b1;
        4'b0011: dec[C_ACT] = 1'b1;
        4'b0010: dec[addr[AP_BIT] ? C_PALL : C_PRE] = 1'b1;
        4'b0001: dec[cke ? C_REF : C_SREF] = 1'b1;
        default: dec[C_MRS] = 1'b1;
      endcase
    end
  end

  always_comb begin
    bank_n = bank_active;
    if (!bad) begin
      if (dec[C_ACT])  bank_n[ba] = 1'b1;
      if (dec[C_PRE])  bank_n[ba] = 1'b0;
      if (dec[C_PALL]) bank_n = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cke_q       <= 1'b1;
      cmd         <= '0;
      illegal     <= 1'b0;
      cmd_addr    <= '0;
      cmd_bank    <= '0;
      auto_pre    <= 1'b0;
      bank_active <= '0;
      pwr_down    <= 1'b0;
      self_ref    <= 1'b0;
      clk_susp    <= 1'b0;
    end else begin
      cke_q       <= cke;
      cmd         <= dec;
      illegal     <= bad;
      bank_active <= bank_n;
      auto_pre    <= rw & addr[AP_BIT];
      if (dec[C_ACT] | dec[C_MRS]) cmd_addr <= addr;
      else if (rw)                 cmd_addr <= ROW_W'(addr[COL_W-1:0]);
      if (dec[C_ACT] | dec[C_PRE] | rw) cmd_bank <= ba;
      if (cke) begin
        pwr_down <= 1'b0;
        self_ref <= 1'b0;
        clk_susp <= 1'b0;
      end else if (enter) begin
        self_ref <= sref_ok;
        clk_susp <= ~sref_ok & burst_busy;
        pwr_down <= ~sref_ok & ~burst_busy;
      end
    end
  end

  // R2
  cmd_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(cmd));
  // R7
  illegal_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> bank_active == $past(bank_active));
  // R6
  sref_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    self_ref |-> bank_active == '0);
  // R8
  mode_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pwr_down, self_ref, clk_susp}));
  // R9
  frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_down | self_ref | clk_susp) |=> cmd == '0);
  // R4
  rw_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd[C_RD] | cmd[C_WR]) & ~illegal) |-> bank_active[cmd_bank]);
endmodule

// File: tb/sim_sdram_cmd_decode.sv
module sim_sdram_cmd_decode;
  logic clk = 0, rst_n = 0;
  logic cs_n = 1, ras_n = 1, cas_n = 1, we_n = 1, cke = 1, burst_busy = 0;
  logic [1:0] ba = 0;
  logic [11:0] addr = 0;
  logic [10:0] cmd;
  logic illegal, auto_pre, pwr_down, self_ref, clk_susp;
  logic [11:0] cmd_addr;
  logic [1:0] cmd_bank;
  logic [3:0] bank_active;
  int nchk = 0, nfail = 0;

  always #2 clk = ~clk;

  sdram_cmd_decode u0 (.clk, .rst_n, .cs_n, .ras_n, .cas_n, .we_n, .cke, .ba, .addr,
    .burst_busy, .cmd, .illegal, .cmd_addr, .cmd_bank, .auto_pre, .bank_active,
    .pwr_down, .self_ref, .clk_susp);

  // {pins, cke, busy, ba, addr, exp cmd, exp illegal, exp banks}
  localparam int NV = 17;
  localparam logic [35:0] VEC [NV] = '{
    {4'b0111,1'b1,1'b0,2'd0,12'h000,11'h002,1'b0,4'b0000}, // R2 nop
    {4'b1111,1'b1,1'b0,2'd0,12'h000,11'h001,1'b0,4'b0000}, // R1 deselect
    {4'b0000,1'b1,1'b0,2'd0,12'h033,11'h080,1'b0,4'b0000}, // R6 mode set idle
    {4'b0001,1'b1,1'b0,2'd0,12'h000,11'h100,1'b0,4'b0000}, // R6 refresh idle
    {4'b0011,1'b1,1'b0,2'd1,12'hABC,11'h004,1'b0,4'b0010}, // R3 activate
    {4'b0011,1'b1,1'b0,2'd1,12'h123,11'h004,1'b1,4'b0010}, // R3 R7 reactivate
    {4'b0101,1'b1,1'b0,2'd2,12'h000,11'h040,1'b1,4'b0010}, // R4 read closed
    {4'b0100,1'b1,1'b0,2'd1,12'h4FF,11'h020,1'b0,4'b0010}, // R4 write open
    {4'b0000,1'b1,1'b0,2'd0,12'h000,11'h080,1'b1,4'b0010}, // R6 mode set busy
    {4'b0001,1'b1,1'b0,2'd0,12'h000,11'h100,1'b1,4'b0010}, // R6 refresh busy
    {4'b0011,1'b1,1'b0,2'd3,12'h000,11'h004,1'b0,4'b1010}, // R3
    {4'b0110,1'b1,1'b0,2'd0,12'h000,11'h400,1'b0,4'b1010}, // R2 burst stop
    {4'b0010,1'b1,1'b0,2'd1,12'h000,11'h008,1'b0,4'b1000}, // R5 single
    {4'b0011,1'b1,1'b0,2'd0,12'h000,11'h004,1'b0,4'b1001}, // R3
    {4'b0010,1'b1,1'b0,2'd0,12'h400,11'h010,1'b0,4'b0000}, // R5 all
    {4'b0101,1'b1,1'b0,2'd0,12'h000,11'h040,1'b1,4'b0000}, // R4 R7
    {4'b1011,1'b1,1'b0,2'd2,12'h000,11'h001,1'b0,4'b0000}  // R1 masked activate
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic [3:0] p, input logic k, input logic b,
                      input logic [1:0] bb, input logic [11:0] a);
    @(negedge clk);
    {cs_n, ras_n, cas_n, we_n} = p;
    cke = k; burst_busy = b; ba = bb; addr = a;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #200000;
    nfail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    #1;
    chk("R10 reset cmd", 32'(cmd), 0);
    chk("R10 reset banks", 32'(bank_active), 0);
    chk("R10 reset modes", 32'({pwr_down, self_ref, clk_susp, illegal}), 0);
    #9 rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][35:32], VEC[i][31], VEC[i][30], VEC[i][29:28], VEC[i][27:16]);
      chk("R2 vector cmd", 32'(cmd), 32'(VEC[i][15:5]));
      chk("R7 vector illegal", 32'(illegal), 32'(VEC[i][4]));
      chk("R3 vector banks", 32'(bank_active), 32'(VEC[i][3:0]));
    end

    // R11 latching
    step(4'b0011, 1, 0, 2'd2, 12'hFED);
    chk("R11 row", 32'(cmd_addr), 32'hFED);
    chk("R11 bank", 32'(cmd_bank), 2);
    step(4'b0100, 1, 0, 2'd2, 12'h5A3);
    chk("R11 column", 32'(cmd_addr), 32'h1A3);
    chk("R11 autopre set", 32'(auto_pre), 1);
    step(4'b0101, 1, 0, 2'd2, 12'h0FF);
    chk("R11 autopre clear", 32'(auto_pre), 0);
    chk("R11 column rd", 32'(cmd_addr), 32'h0FF);

    // R8 clock suspend during burst
    step(4'b0111, 0, 1, 2'd0, 0);
    chk("R8 suspend", 32'({pwr_down, self_ref, clk_susp}), 3'b001);
    chk("R8 nop decoded", 32'(cmd), 32'h002);
    step(4'b0011, 0, 1, 2'd3, 0);
    chk("R9 frozen cmd", 32'(cmd), 0);
    chk("R9 frozen banks", 32'(bank_active), 4'b0100);
    step(4'b0111, 1, 0, 2'd0, 0);
    chk("R9 exit cmd", 32'(cmd), 0);
    chk("R9 exit clear", 32'({pwr_down, self_ref, clk_susp}), 0);

    // R8 power-down after closing banks
    step(4'b0010, 1, 0, 2'd0, 12'h400);
    step(4'b0111, 0, 0, 2'd0, 0);
    chk("R8 power-down", 32'({pwr_down, self_ref, clk_susp}), 3'b100);
    step(4'b0011, 0, 0, 2'd1, 0);
    chk("R9 ignored act", 32'(bank_active), 0);
    step(4'b0111, 1, 0, 2'd0, 0);
    step(4'b0111, 1, 0, 2'd0, 0);
    chk("R9 decoding resumes", 32'(cmd), 32'h002);

    // R8 self-refresh
    step(4'b0001, 0, 0, 2'd0, 0);
    chk("R8 sref cmd", 32'(cmd), 32'h200);
    chk("R8 sref mode", 32'({pwr_down, self_ref, clk_susp}), 3'b010);
    for (int j = 0; j < 3; j++) begin
      step(4'b0011, 0, 0, 2'd0, 0);
      chk("R9 sref hold", 32'({self_ref, cmd}), 32'h800);
    end
    step(4'b0111, 1, 0, 2'd0, 0);
    chk("R9 sref exit", 32'(self_ref), 0);

    // R6 self-refresh refused with open bank
    step(4'b0011, 1, 0, 2'd0, 0);
    step(4'b0001, 0, 0, 2'd0, 0);
    chk("R6 sref illegal", 32'(illegal), 1);
    chk("R8 falls to power-down", 32'({pwr_down, self_ref, clk_susp}), 3'b100);
    chk("R7 bank kept", 32'(bank_active), 4'b0001);
    step(4'b0111, 1, 0, 2'd0, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule